// File: doc/BRIEF.md
# Undervoltage Fault Response Controller

This controller decides what a power stage does when its output undervoltage comparator trips. It follows the stage from power-up through the soft-start ramp into regulation. A comparator trip is taken as a fault only once the ramp has finished, and only if the trip lasts for a programmable number of prescaled ticks. A confirmed fault then shuts the stage down in one of two ways, chosen by a restart configuration bit:

- **Latched off:** both drivers stay off until the enable input is cycled or the supply-good input drops.
- **Hiccup:** both drivers are held off for a fixed sleep time, derived from a clock-frequency parameter and nominally 56 ms. The controller then requests a new soft-start. There is no limit on how many times it retries.

Enable low or supply-good low forces the drivers off from any state. When both return high, a restart request is issued.

Top module: `uv_fault_ctrl`

## Requirements
- R1: While `rst_n` is low, and after its release while `en` is low, `drv_off` is 1 and `restart_req`, `fault_latched` and `hiccup_active` are all 0.
- R2: With `en` and `vcc_good` both high in the off state, the next cycle enters soft-start. In that cycle `drv_off` goes to 0 and `restart_req` is 1 for exactly that one cycle.
- R3: During soft-start (`ss_done` low), `uv_flag` has no effect: `drv_off`, `fault_latched` and `hiccup_active` remain 0.
- R4: After `ss_done` is seen high, a fault is confirmed only when `uv_flag` has been high for `dly_cfg` × `DLY_PRESCALE` consecutive cycles of the qualifying state. If `uv_flag` falls earlier, no fault is taken and the count starts again from zero.
- R5: With `dly_cfg` = 0, a `uv_flag` seen high in regulation shuts the stage down on the next clock.
- R6: A confirmed fault with `restart_cfg` = 0 sets `drv_off` = 1 and `fault_latched` = 1. Both stay set whatever `uv_flag` and `ss_done` do.
- R7: The latched state ends only when `en` or `vcc_good` goes low. That gives the off state: `fault_latched` = 0 and `drv_off` = 1. Re-raising the inputs restarts as in R2.
- R8: A confirmed fault with `restart_cfg` = 1 holds `drv_off` = 1 and `hiccup_active` = 1 for `CLK_HZ`/1000 × `SLEEP_MS` cycles. The controller then re-enters soft-start with a one-cycle `restart_req`, and this repeats without limit.
- R9: `en` low or `vcc_good` low puts the off state in place on the next clock from any state. This overrides a fault confirmation or sleep completion falling on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_good | input | 1 | Supply-good indication; low acts as a supply reset |
| en | input | 1 | Enable pin |
| uv_flag | input | 1 | Output undervoltage comparator flag |
| ss_done | input | 1 | Soft-start ramp finished |
| dly_cfg | input | DLY_W | Response delay in prescaled ticks |
| restart_cfg | input | 1 | 0 = latch off, 1 = hiccup retry |
| drv_off | output | 1 | Force both drivers off |
| restart_req | output | 1 | One-cycle request to start the soft-start ramp |
| fault_latched | output | 1 | Latched-off fault state |
| hiccup_active | output | 1 | Hiccup sleep in progress |

## Verification
Two events can fall on the same clock edge:

- an enable drop and the expiry of the response delay;
- a supply-good drop and the last cycle of the hiccup sleep.

The bench's behavioural model tracks the qualifying cycle count and the sleep count. From the model it picks the exact negative edge before the expiring edge and lowers `en` (or `vcc_good`) there. The outputs are then compared with the model on every cycle: the expected result is the plain off state, with neither the latched flag nor a restart request.

// File: rtl/uvf_pkg.sv
package uvf_pkg;
  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_SS     = 3'd1,
    ST_RUN    = 3'd2,
    ST_QUAL   = 3'd3,
    ST_LATCH  = 3'd4,
    ST_HICCUP = 3'd5
  } uvf_state_e;
endpackage

// File: rtl/uvf_prescaler.sv
module uvf_prescaler #(
  parameter int PRE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int W = (PRE > 1) ? $clog2(PRE) : 1;
  localparam logic [W-1:0] LASTV = W'(PRE - 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == LASTV);
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: ticks are spaced PRE cycles apart while running
  generate
    if (PRE > 1) begin : g_sp
      a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/uvf_counter.sv
module uvf_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] last,
  output logic         hit
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    hit   = inc && !clr && (cnt_q == last);
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4 / R8: a terminal count is reported once before the count moves on
  a_r4_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);
endmodule

// File: rtl/uv_fault_ctrl.sv
module uv_fault_ctrl
  import uvf_pkg::*;
#(
  parameter int CLK_HZ       = 100_000_000,
  parameter int SLEEP_MS     = 56,
  parameter int DLY_PRESCALE = 100,
  parameter int DLY_W        = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vcc_good,
  input  logic             en,
  input  logic             uv_flag,
  input  logic             ss_done,
  input  logic [DLY_W-1:0] dly_cfg,
  input  logic             restart_cfg,
  output logic             drv_off,
  output logic             restart_req,
  output logic             fault_latched,
  output logic             hiccup_active
);
  localparam int SLEEP_CYC = (CLK_HZ / 1000) * SLEEP_MS;
  localparam int SLEEP_W   = $clog2(SLEEP_CYC + 1);
  localparam logic [SLEEP_W-1:0] SLEEP_LAST = SLEEP_W'(SLEEP_CYC - 1);

  uvf_state_e state_q, state_d, act_st;
  logic go, dly_zero, pre_tick, dly_hit, sleep_hit, rr_d;
  logic [DLY_W-1:0] dly_last;

  assign go       = en && vcc_good;
  assign dly_zero = (dly_cfg == '0);
  assign dly_last = dly_cfg - 1'b1;
  assign act_st   = restart_cfg ? ST_HICCUP : ST_LATCH;

  uvf_prescaler #(.PRE(DLY_PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_QUAL), .tick(pre_tick));

  uvf_counter #(.W(DLY_W)) u_dly (
    .clk(clk), .rst_n(rst_n), .clr(state_q != ST_QUAL), .inc(pre_tick),
    .last(dly_last), .hit(dly_hit));

  uvf_counter #(.W(SLEEP_W)) u_sleep (
    .clk(clk), .rst_n(rst_n), .clr(state_q != ST_HICCUP), .inc(1'b1),
    .last(SLEEP_LAST), .hit(sleep_hit));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:    if (go) state_d = ST_SS;
      ST_SS:     if (ss_done) state_d = ST_RUN;
      ST_RUN:    if (uv_flag) state_d = dly_zero ? act_st : ST_QUAL;
      ST_QUAL: begin
        if (!uv_flag)     state_d = ST_RUN;
        else if (dly_hit) state_d = act_st;
      end
      ST_LATCH:  state_d = ST_LATCH;
      ST_HICCUP: if (sleep_hit) state_d = ST_SS;
      default:   state_d = ST_OFF;
    endcase
    if (!go) state_d = ST_OFF;
    rr_d = (state_d == ST_SS) && (state_q != ST_SS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_OFF;
      restart_req <= 1'b0;
    end else begin
      state_q     <= state_d;
      restart_req <= rr_d;
    end
  end

  assign drv_off       = (state_q == ST_OFF) || (state_q == ST_LATCH) ||
                         (state_q == ST_HICCUP);
  assign fault_latched = (state_q == ST_LATCH);
  assign hiccup_active = (state_q == ST_HICCUP);

  a_r9_force_off: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> (drv_off && !fault_latched && !hiccup_active && !restart_req));
  a_r6_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_latched && go) |=> fault_latched);
  a_r3_masked_ramp: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SS) |=> (!fault_latched && !hiccup_active));
  a_r2_single_req: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |=> !restart_req);
  a_r8_sleep_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (hiccup_active && !sleep_hit && go) |=> hiccup_active);
  a_r8_sleep_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (hiccup_active && sleep_hit && go) |=> (restart_req && !drv_off));
endmodule

// File: tb/sim_uv_fault_ctrl.sv
module sim_uv_fault_ctrl;
  localparam int CLK_HZ = 1000;
  localparam int SLEEP_MS = 56;
  localparam int PRE = 3;
  localparam int DLY_W = 4;
  localparam int SLEEP = (CLK_HZ / 1000) * SLEEP_MS;

  logic clk = 1'b0;
  logic rst_n, vcc_good, en, uv_flag, ss_done, restart_cfg;
  logic [DLY_W-1:0] dly_cfg;
  logic drv_off, restart_req, fault_latched, hiccup_active;

  always #5 clk = ~clk;

  uv_fault_ctrl #(.CLK_HZ(CLK_HZ), .SLEEP_MS(SLEEP_MS), .DLY_PRESCALE(PRE),
                  .DLY_W(DLY_W)) u0 (
    .clk(clk), .rst_n(rst_n), .vcc_good(vcc_good), .en(en), .uv_flag(uv_flag),
    .ss_done(ss_done), .dly_cfg(dly_cfg), .restart_cfg(restart_cfg),
    .drv_off(drv_off), .restart_req(restart_req),
    .fault_latched(fault_latched), .hiccup_active(hiccup_active));

  // behavioural model: 0 off, 1 ramp, 2 regulate, 3 qualify, 4 latched, 5 sleep
  int m_st, m_q, m_h, n;
  logic m_rr;
  int vectors = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_q = 0; m_h = 0; m_rr = 1'b0;
    end else begin
      n = m_st;
      case (m_st)
        0: n = 1;
        1: if (ss_done) n = 2;
        2: if (uv_flag) n = (dly_cfg == 0) ? (restart_cfg ? 5 : 4) : 3;
        3: if (!uv_flag) n = 2;
           else if (m_q == int'(dly_cfg) * PRE - 1) n = restart_cfg ? 5 : 4;
        5: if (m_h == SLEEP - 1) n = 1;
        default: n = m_st;
      endcase
      if (!(en && vcc_good)) n = 0;
      m_rr = (n == 1) && (m_st != 1);
      m_q  = (n == 3 && m_st == 3) ? m_q + 1 : 0;
      m_h  = (n == 5 && m_st == 5) ? m_h + 1 : 0;
      m_st = n;
    end
  end

  task automatic step();
    logic [3:0] exp_v, act_v;
    @(negedge clk);
    cycles++;
    exp_v = {(m_st == 0 || m_st == 4 || m_st == 5), m_rr, m_st == 4, m_st == 5};
    act_v = {drv_off, restart_req, fault_latched, hiccup_active};
    vectors++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s cycle %0d {drv_off,restart_req,latched,hiccup} actual %b expected %b",
               cur_req, cycles, act_v, exp_v);
    end
  endtask

  task automatic run(int k);
    for (int i = 0; i < k; i++) step();
  endtask

  initial begin
    int guard = 0;
    while (guard < 50000) begin @(posedge clk); guard++; end
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; vcc_good = 1'b1; en = 1'b0; uv_flag = 1'b0; ss_done = 1'b0;
    dly_cfg = 4'd4; restart_cfg = 1'b0;
    cur_req = "R1"; run(3);
    rst_n = 1'b1; run(4);
    cur_req = "R2"; en = 1'b1; run(3);
    cur_req = "R3"; uv_flag = 1'b1; run(6);
    uv_flag = 1'b0; ss_done = 1'b1;
    cur_req = "R4"; run(3);
    uv_flag = 1'b1; run(8); uv_flag = 1'b0; run(3);
    uv_flag = 1'b1; run(11); uv_flag = 1'b0; run(4);
    cur_req = "R6"; uv_flag = 1'b1; run(16);
    uv_flag = 1'b0; ss_done = 1'b0; run(5); uv_flag = 1'b1; run(3);
    cur_req = "R7"; en = 1'b0; run(3); uv_flag = 1'b0; en = 1'b1; run(3);
    ss_done = 1'b1; run(2);
    cur_req = "R6"; uv_flag = 1'b1; run(15);
    cur_req = "R7"; vcc_good = 1'b0; run(2); vcc_good = 1'b1; uv_flag = 1'b0; run(3);
    cur_req = "R5"; dly_cfg = 4'd0; uv_flag = 1'b1; run(2);
    cur_req = "R7"; en = 1'b0; uv_flag = 1'b0; run(2); en = 1'b1; run(3);
    cur_req = "R8"; dly_cfg = 4'd2; restart_cfg = 1'b1; uv_flag = 1'b1;
    run(3 * (SLEEP + 2 * PRE + 4));
    // R9: enable drops on the very edge the delay expires
    cur_req = "R9"; uv_flag = 1'b0; run(3);
    uv_flag = 1'b1;
    while (!(m_st == 3 && m_q == int'(dly_cfg) * PRE - 1)) step();
    en = 1'b0; run(3);
    uv_flag = 1'b0; en = 1'b1; run(4);
    // R9: supply drops on the last sleep cycle
    uv_flag = 1'b1;
    while (!(m_st == 5 && m_h == SLEEP - 1)) step();
    vcc_good = 1'b0; run(3);
    vcc_good = 1'b1; uv_flag = 1'b0; run(4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule